// File: doc/BRIEF.md
# Pausable Device Clock Generator

This block turns a fast system clock into a slower clock for an external peripheral. The rate is set as a half-period count N in system cycles. Each high phase and each low phase lasts exactly N cycles. After reset, N is 312. With a 250 MHz system clock this gives a period of 624 cycles, about 400 kHz, which suits card or flash bring-up. Software can later load a smaller N to reach 25, 50, 100 MHz and faster, as far as the system clock allows. A new setting is held pending and takes effect only at a period boundary. Each period starts with the rising edge and ends at the low idle level, so a change of rate never cuts a phase short.

A transfer controller drives a plain transfer request. While the request is high, the block first holds the clock low for one full period. It then emits whole periods until the request drops. After that it holds low for a programmable number of periods and pulses a release strobe, at which point chip select may be let go.

A pause input freezes the clock at a period boundary and resumes it later with a whole period, so a receiver can stop a device before its buffer overflows. In double-data-rate mode, a second output trails the base clock by a quarter period. Single-cycle strobes announce every base edge one cycle ahead, so that data-launch logic can line up with them. There is no data stream in this block, so every pin is a plain control or status level.

Top module: `devclk_gen`

## Requirements
- R1: After reset, all outputs are low, and the active settings are half count 312, double-data-rate off and tail count 2.
- R2: Whenever the clock runs, every high phase and every low phase of `dev_clk_o` lasts exactly N system cycles, where N is the active half count. No shortened phase is ever emitted.
- R3: `busy_o` is high exactly while the sequencer is not in its idle state, and `dev_clk_o` stays low whenever `busy_o` is low.
- R4: When `xfer_i` is sampled high by an idle block, the first rising edge of `dev_clk_o` appears 2N+2 cycles after that sampling edge. This is one full idle lead period plus the fixed two-cycle output latency.
- R5: `rise_stb_o` is high for exactly the one cycle before each rising edge of `dev_clk_o`, and `fall_stb_o` likewise before each falling edge. Neither fires at any other time.
- R6: When the active double-data-rate bit is 1, `dev_clk90_o` rises N/2 cycles after each rise of `dev_clk_o` and falls N/2 cycles after each fall. When the bit is 0, it stays low.
- R7: When `xfer_i` drops, the current period completes and T idle periods follow, where T is the active tail count. Then `cs_release_o` pulses for one cycle, N+2NT cycles after the last falling edge of `dev_clk_o`.
- R8: If `pause_i` is high at a period boundary, both clock outputs hold low while `busy_o` stays high. If `pause_i` is sampled low at edge e, `dev_clk_o` rises at e+2 with a full period.
- R9: A pulse on `cfg_wr_i` loads the half count, the double-data-rate bit and the tail count into a pending slot. The slot becomes active at the next boundary: any cycle while idle or paused, or the last cycle of a period. A write made while a period runs is therefore held until that period ends.
- R10: A written half count below 2 becomes 2. With the double-data-rate bit set, an odd count is rounded up to the next even value; the all-ones value is rounded down instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| xfer_i | input | 1 | Transfer request, level |
| pause_i | input | 1 | Freeze clock at next boundary, level |
| cfg_wr_i | input | 1 | Load the three configuration fields |
| cfg_half_i | input | HALF_W | Requested half-period count N |
| cfg_ddr_i | input | 1 | Enable quarter-shifted output |
| cfg_tail_i | input | TAIL_W | Idle periods before release |
| dev_clk_o | output | 1 | Device clock, idle low |
| dev_clk90_o | output | 1 | Device clock delayed by a quarter period |
| rise_stb_o | output | 1 | Strobe one cycle before a rising edge |
| fall_stb_o | output | 1 | Strobe one cycle before a falling edge |
| busy_o | output | 1 | Sequencer not idle |
| cs_release_o | output | 1 | One-cycle pulse: chip select may drop |

## Verification
A wrong sequencer state shows on `busy_o` in the same cycle. It shows on `dev_clk_o` and the quarter-shifted output within two cycles, because both come from the state through a fixed pair of flops. A stale or early ratio shows as a phase of the wrong length, and the falling edge that ends that phase exposes it. A wrong tail count moves the release pulse by whole periods. The bench therefore compares every output against an independent cycle model on every clock and also measures phase lengths, lead and tail gaps directly.

// File: rtl/devclk_pkg.sv
package devclk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_RUN  = 3'd2,
    ST_HOLD = 3'd3,
    ST_TAIL = 3'd4
  } seq_state_e;

  localparam int unsigned MIN_HALF_COUNT = 2;

endpackage

// File: rtl/devclk_cfg.sv
module devclk_cfg
  import devclk_pkg::*;
#(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned TAIL_W    = 4,
  parameter int unsigned BOOT_HALF = 312,
  parameter int unsigned BOOT_TAIL = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [HALF_W-1:0] wr_half_i,
  input  logic              wr_ddr_i,
  input  logic [TAIL_W-1:0] wr_tail_i,
  input  logic              apply_i,
  output logic [HALF_W-1:0] cur_half_o,
  output logic              cur_ddr_o,
  output logic [TAIL_W-1:0] nxt_tail_o
);

  localparam logic [HALF_W-1:0] MIN_H = HALF_W'(MIN_HALF_COUNT);
  localparam logic [HALF_W-1:0] MAX_H = '1;

  logic [HALF_W-1:0] cur_half_q, pend_half_q, legal_half;
  logic [TAIL_W-1:0] cur_tail_q, pend_tail_q;
  logic              cur_ddr_q, pend_ddr_q, pend_v_q;
  logic              take;

  // Clamp to the minimum; in double-data-rate mode force an even count
  always_comb begin
    legal_half = (wr_half_i < MIN_H) ? MIN_H : wr_half_i;
    if (wr_ddr_i && legal_half[0]) begin
      legal_half = (legal_half == MAX_H) ? legal_half - HALF_W'(1)
                                         : legal_half + HALF_W'(1);
    end
  end

  assign take = apply_i && pend_v_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cur_half_q  <= HALF_W'(BOOT_HALF);
      cur_ddr_q   <= 1'b0;
      cur_tail_q  <= TAIL_W'(BOOT_TAIL);
      pend_half_q <= HALF_W'(BOOT_HALF);
      pend_ddr_q  <= 1'b0;
      pend_tail_q <= TAIL_W'(BOOT_TAIL);
      pend_v_q    <= 1'b0;
    end else begin
      if (take) begin
        cur_half_q <= pend_half_q;
        cur_ddr_q  <= pend_ddr_q;
        cur_tail_q <= pend_tail_q;
      end
      if (wr_i) begin
        pend_half_q <= legal_half;
        pend_ddr_q  <= wr_ddr_i;
        pend_tail_q <= wr_tail_i;
        pend_v_q    <= 1'b1;
      end else if (take) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign cur_half_o = cur_half_q;
  assign cur_ddr_o  = cur_ddr_q;
  assign nxt_tail_o = take ? pend_tail_q : cur_tail_q;

endmodule

// File: rtl/devclk_seq.sv
module devclk_seq
  import devclk_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned TAIL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic              pause_i,
  input  logic [HALF_W-1:0] cur_half_i,
  input  logic [TAIL_W-1:0] nxt_tail_i,
  output seq_state_e        state_o,
  output logic [HALF_W:0]   pos_o,
  output logic              bound_o,
  output logic              going_o
);

  localparam int unsigned PW = HALF_W + 1;

  seq_state_e        state_q, state_d, dec_state;
  logic [PW-1:0]     pos_q, pos_d, last_pos;
  logic [TAIL_W-1:0] left_q, left_d;
  logic              at_end, dec_going, going;

  assign last_pos = {cur_half_i, 1'b0} - PW'(1);
  assign at_end   = (pos_q == last_pos);

  // Choice taken when a lead or run period ends, or while paused
  always_comb begin
    dec_going = 1'b0;
    if (!xfer_i) begin
      if (nxt_tail_i == '0) begin
        dec_state = ST_IDLE;
        dec_going = 1'b1;
      end else begin
        dec_state = ST_TAIL;
      end
    end else if (pause_i) begin
      dec_state = ST_HOLD;
    end else begin
      dec_state = ST_RUN;
    end
  end

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    left_d  = left_q;
    going   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (xfer_i) begin
          state_d = ST_LEAD;
          pos_d   = '0;
        end
      end
      ST_HOLD: begin
        state_d = dec_state;
        going   = dec_going;
        left_d  = nxt_tail_i;
        pos_d   = '0;
      end
      ST_LEAD, ST_RUN: begin
        if (at_end) begin
          state_d = dec_state;
          going   = dec_going;
          left_d  = nxt_tail_i;
          pos_d   = '0;
        end else begin
          pos_d = pos_q + PW'(1);
        end
      end
      ST_TAIL: begin
        if (at_end) begin
          pos_d = '0;
          if (left_q == TAIL_W'(1)) begin
            state_d = ST_IDLE;
            going   = 1'b1;
          end else begin
            left_d = left_q - TAIL_W'(1);
          end
        end else begin
          pos_d = pos_q + PW'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        pos_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      left_q  <= left_d;
    end
  end

  assign state_o = state_q;
  assign pos_o   = pos_q;
  assign bound_o = (state_q == ST_IDLE) || (state_q == ST_HOLD) || at_end;
  assign going_o = going;

endmodule

// File: rtl/devclk_wave.sv
module devclk_wave
  import devclk_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_i,
  input  logic [HALF_W:0]   pos_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              ddr_i,
  input  logic              going_i,
  output logic              dclk_o,
  output logic              dclk90_o,
  output logic              rise_o,
  output logic              fall_o,
  output logic              release_o
);

  localparam int unsigned PW = HALF_W + 1;

  logic [PW-1:0] half_w, quarter, q_end;
  logic          in_run, base_pre, quad_pre;
  logic          base_s1, quad_s1, rel_s1, rel_s2;

  assign half_w  = {1'b0, half_i};
  assign quarter = {2'b00, half_i[HALF_W-1:1]};
  assign q_end   = half_w + quarter;
  assign in_run  = (state_i == ST_RUN);

  // Within a period: base high for the first N cycles, shifted copy N/2 later
  assign base_pre = in_run && (pos_i < half_w);
  assign quad_pre = in_run && ddr_i && (pos_i >= quarter) && (pos_i < q_end);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      base_s1   <= 1'b0;
      quad_s1   <= 1'b0;
      dclk_o    <= 1'b0;
      dclk90_o  <= 1'b0;
      rise_o    <= 1'b0;
      fall_o    <= 1'b0;
      rel_s1    <= 1'b0;
      rel_s2    <= 1'b0;
      release_o <= 1'b0;
    end else begin
      base_s1   <= base_pre;
      quad_s1   <= quad_pre;
      dclk_o    <= base_s1;
      dclk90_o  <= quad_s1;
      rise_o    <= base_pre & ~base_s1;
      fall_o    <= ~base_pre & base_s1;
      rel_s1    <= going_i;
      rel_s2    <= rel_s1;
      release_o <= rel_s2;
    end
  end

endmodule

// File: rtl/devclk_gen.sv
module devclk_gen
  import devclk_pkg::*;
#(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned TAIL_W    = 4,
  parameter int unsigned BOOT_HALF = 312,
  parameter int unsigned BOOT_TAIL = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic              pause_i,
  input  logic              cfg_wr_i,
  input  logic [HALF_W-1:0] cfg_half_i,
  input  logic              cfg_ddr_i,
  input  logic [TAIL_W-1:0] cfg_tail_i,
  output logic              dev_clk_o,
  output logic              dev_clk90_o,
  output logic              rise_stb_o,
  output logic              fall_stb_o,
  output logic              busy_o,
  output logic              cs_release_o
);

  seq_state_e        state;
  logic [HALF_W:0]   pos;
  logic [HALF_W-1:0] act_half;
  logic [TAIL_W-1:0] nxt_tail;
  logic              act_ddr, bound, going;

  devclk_cfg #(
    .HALF_W(HALF_W), .TAIL_W(TAIL_W),
    .BOOT_HALF(BOOT_HALF), .BOOT_TAIL(BOOT_TAIL)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(cfg_wr_i), .wr_half_i(cfg_half_i), .wr_ddr_i(cfg_ddr_i), .wr_tail_i(cfg_tail_i),
    .apply_i(bound),
    .cur_half_o(act_half), .cur_ddr_o(act_ddr), .nxt_tail_o(nxt_tail)
  );

  devclk_seq #(.HALF_W(HALF_W), .TAIL_W(TAIL_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .xfer_i(xfer_i), .pause_i(pause_i),
    .cur_half_i(act_half), .nxt_tail_i(nxt_tail),
    .state_o(state), .pos_o(pos), .bound_o(bound), .going_o(going)
  );

  devclk_wave #(.HALF_W(HALF_W)) u_wave (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .state_i(state), .pos_i(pos), .half_i(act_half), .ddr_i(act_ddr), .going_i(going),
    .dclk_o(dev_clk_o), .dclk90_o(dev_clk90_o),
    .rise_o(rise_stb_o), .fall_o(fall_stb_o), .release_o(cs_release_o)
  );

  assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/devclk_gen_chk.sv
module devclk_gen_chk #(
  parameter int unsigned HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dev_clk_o,
  input logic              dev_clk90_o,
  input logic              rise_stb_o,
  input logic              fall_stb_o,
  input logic              busy_o,
  input logic              cs_release_o,
  input logic [HALF_W-1:0] act_half
);

  logic [HALF_W:0] hi_cnt;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) hi_cnt <= '0;
    else         hi_cnt <= dev_clk_o ? hi_cnt + 1'b1 : '0;
  end

  // R2: a completed high phase lasts exactly the half count active within its period
  p_phase_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_clk_o) |-> (hi_cnt == {1'b0, $past(act_half, 2)}));

  // R3: no clock while idle
  p_idle_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dev_clk_o);

  // R5: strobes precede the matching edge
  p_rise_ahead_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_stb_o |=> $rose(dev_clk_o));
  p_fall_ahead_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb_o |=> $fell(dev_clk_o));
  p_stb_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_stb_o, fall_stb_o}));

  // R6: the shifted copy rises inside a high phase and falls inside a low phase
  p_quad_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_clk90_o) |-> dev_clk_o);
  p_quad_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_clk90_o) |-> !dev_clk_o);

  // R7: release only with both clocks parked low
  p_release_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_release_o |-> (!dev_clk_o && !dev_clk90_o));

endmodule

bind devclk_gen devclk_gen_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .dev_clk_o(dev_clk_o), .dev_clk90_o(dev_clk90_o),
  .rise_stb_o(rise_stb_o), .fall_stb_o(fall_stb_o),
  .busy_o(busy_o), .cs_release_o(cs_release_o),
  .act_half(act_half)
);

// File: tb/test_devclk_gen.sv
module test_devclk_gen;

  localparam int HW = 16;
  localparam int TW = 4;
  localparam int BOOT = 312;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xfer = 1'b0, pause = 1'b0, wr = 1'b0, wr_ddr = 1'b0;
  logic [HW-1:0] wr_half = '0;
  logic [TW-1:0] wr_tail = '0;
  logic dclk, dclk90, rise, fall, busy, rel;

  int errors = 0, checks = 0, cyc = 0, last_fall = 0;
  bit cmp_on = 1'b0, prev_d = 1'b0;

  always #2 clk = ~clk;

  devclk_gen #(.HALF_W(HW), .TAIL_W(TW), .BOOT_HALF(BOOT), .BOOT_TAIL(2)) i_devclk_gen (
    .clk_i(clk), .rst_ni(rst_n), .xfer_i(xfer), .pause_i(pause),
    .cfg_wr_i(wr), .cfg_half_i(wr_half), .cfg_ddr_i(wr_ddr), .cfg_tail_i(wr_tail),
    .dev_clk_o(dclk), .dev_clk90_o(dclk90), .rise_stb_o(rise), .fall_stb_o(fall),
    .busy_o(busy), .cs_release_o(rel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int legal(input int h, input int d);
    int v;
    v = (h < 2) ? 2 : h;
    if (d != 0 && (v % 2) == 1) v = (v == 65535) ? v - 1 : v + 1;
    return v;
  endfunction

  // Behavioural reference: modes 0 idle, 1 lead, 2 run, 3 paused, 4 tail
  int m_mode, m_pos, m_n, m_ddr, m_tcfg, m_left, p_v, p_n, p_d, p_t;
  bit h_d[3], h_q[3], h_g[3];
  bit m_busy;

  always @(posedge clk) begin
    bit endp, bnd, go;
    cyc++;
    if (!rst_n) begin
      m_mode = 0; m_pos = 0; m_n = BOOT; m_ddr = 0; m_tcfg = 2; m_left = 0;
      p_v = 0; p_n = BOOT; p_d = 0; p_t = 2; m_busy = 0;
      for (int i = 0; i < 3; i++) begin h_d[i] = 0; h_q[i] = 0; h_g[i] = 0; end
    end else begin
      endp = (m_mode == 1 || m_mode == 2 || m_mode == 4) && (m_pos == 2 * m_n - 1);
      bnd = (m_mode == 0) || (m_mode == 3) || endp;
      if (bnd && p_v != 0) begin m_n = p_n; m_ddr = p_d; m_tcfg = p_t; p_v = 0; end
      go = 0;
      if (m_mode == 3 || ((m_mode == 1 || m_mode == 2) && endp)) begin
        m_pos = 0;
        if (!xfer) begin
          if (m_tcfg == 0) begin m_mode = 0; go = 1; end
          else begin m_mode = 4; m_left = m_tcfg; end
        end else if (pause) m_mode = 3;
        else m_mode = 2;
      end else if (m_mode == 0) begin
        if (xfer) begin m_mode = 1; m_pos = 0; end
      end else if (m_mode == 4 && endp) begin
        m_pos = 0;
        if (m_left == 1) begin m_mode = 0; go = 1; end
        else m_left--;
      end else begin
        m_pos++;
      end
      if (wr) begin p_n = legal(int'(wr_half), int'(wr_ddr)); p_d = int'(wr_ddr); p_t = int'(wr_tail); p_v = 1; end
      h_d[2] = h_d[1]; h_d[1] = h_d[0];
      h_q[2] = h_q[1]; h_q[1] = h_q[0];
      h_g[2] = h_g[1]; h_g[1] = h_g[0];
      h_d[0] = (m_mode == 2) && (m_pos < m_n);
      h_q[0] = (m_mode == 2) && (m_ddr != 0) && (m_pos >= m_n / 2) && (m_pos < m_n + m_n / 2);
      h_g[0] = go;
      m_busy = (m_mode != 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(dclk == h_d[2], "R2 dev clock level", int'(dclk), int'(h_d[2]));
      chk(dclk90 == h_q[2], "R6 shifted clock level", int'(dclk90), int'(h_q[2]));
      chk(rise == (h_d[1] && !h_d[2]), "R5 rise strobe", int'(rise), int'(h_d[1] && !h_d[2]));
      chk(fall == (!h_d[1] && h_d[2]), "R5 fall strobe", int'(fall), int'(!h_d[1] && h_d[2]));
      chk(busy == m_busy, "R3 busy", int'(busy), int'(m_busy));
      chk(rel == h_g[2], "R7 release", int'(rel), int'(h_g[2]));
    end
    if (prev_d && !dclk) last_fall = cyc;
    prev_d = dclk;
  end

  task automatic cfg_write(input int h, input bit d, input int t);
    wr_half = HW'(h); wr_ddr = d; wr_tail = TW'(t); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic meas_high(output int len);
    len = 0;
    while (dclk) @(negedge clk);
    while (!dclk) @(negedge clk);
    while (dclk) begin len++; @(negedge clk); end
  endtask

  task automatic wait_release(input int gap, input string req);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rel) break;
    end
    chk(rel == 1'b1, req, int'(rel), 1);
    chk(cyc - last_fall == gap, req, cyc - last_fall, gap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int e, len, k;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet outputs after reset
    chk(!dclk && !dclk90 && !rise && !fall && !busy && !rel, "R1 reset outputs",
        int'({dclk, dclk90, rise, fall, busy, rel}), 0);

    // R4: lead period at the boot rate (also shows the R1 boot half count)
    xfer = 1'b1;
    e = cyc + 1;
    @(negedge clk);
    while (!dclk) @(negedge clk);
    chk(cyc == e + 2 * BOOT + 2, "R4 first rise at boot rate", cyc - e, 2 * BOOT + 2);
    meas_high(len);
    chk(len == BOOT, "R2 boot high phase", len, BOOT);
    xfer = 1'b0;
    wait_release(BOOT + 2 * BOOT * 2, "R7 tail of two periods");

    // R10 and R6: odd count with double data rate rounds to 4
    cfg_write(3, 1'b1, 1);
    xfer = 1'b1;
    meas_high(len);
    chk(len == 4, "R10 odd rounded up", len, 4);
    repeat (20) @(negedge clk);
    pause = 1'b1;
    repeat (60) @(negedge clk);
    chk(busy && !dclk && !dclk90, "R8 paused low", int'({busy, dclk, dclk90}), 4);
    pause = 1'b0;
    repeat (2) @(negedge clk);
    chk(!dclk, "R8 still low one cycle after release", int'(dclk), 0);
    @(negedge clk);
    chk(dclk, "R8 resume rise", int'(dclk), 1);

    // R9: write while busy is held, then applied
    cfg_write(6, 1'b0, 0);
    repeat (20) @(negedge clk);
    meas_high(len);
    chk(len == 6, "R9 pending ratio applied", len, 6);
    xfer = 1'b0;
    wait_release(6, "R7 zero tail");

    // R10: clamp to 2, then odd 7 in double-data-rate mode becomes 8
    cfg_write(0, 1'b1, 3);
    xfer = 1'b1;
    meas_high(len);
    chk(len == 2, "R10 clamp to two", len, 2);
    cfg_write(7, 1'b1, 3);
    repeat (30) @(negedge clk);
    meas_high(len);
    chk(len == 8, "R10 seven rounds to eight", len, 8);
    while (dclk) @(negedge clk);
    while (!dclk) @(negedge clk);
    k = 0;
    while (!dclk90 && k < 100) begin k++; @(negedge clk); end
    chk(k == 4, "R6 quarter lag", k, 4);
    xfer = 1'b0;
    wait_release(8 + 2 * 8 * 3, "R7 tail of three periods");

    // R3: stays parked while idle
    repeat (50) @(negedge clk);
    chk(!dclk && !busy && !dclk90, "R3 idle parked", int'({dclk, busy, dclk90}), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule